// File: doc/BRIEF.md
# Same-Width Unsigned Multiplier with Overflow Detection

This combinational block multiplies two unsigned operands of equal width and returns a product of that same width. The product is the low half of the true double-width result, so a result that does not fit simply wraps. Next to the product, the block raises an overflow flag whenever the true product does not fit in the operand width.

A cheap early-warning signal comes from the bit positions of the highest set bit in each operand. Call these positions p and q, counted from 0. When p+q reaches the operand width, the product cannot fit. When p+q is at most the width minus two, the product always fits. Only when p+q is exactly the width minus one must the upper half of the full product be examined.

The block suits datapaths where every integer has one width and a consumer must know when a multiply has lost information. The early-warning output lets a consumer act on the sure cases before the exact result is needed.

Top module: `mulov_top`

## Requirements
- R1: `prod_lo` equals (`op_a` × `op_b`) modulo 256 for every operand pair.
- R2: `ovf` is 1 exactly when the true product `op_a` × `op_b` exceeds 255, for all 65,536 operand pairs.
- R3: `early_ovf` is 1 exactly when both operands are non-zero and p+q ≥ 8, where p and q are the bit indices (0 = least significant) of the highest set bit of `op_a` and `op_b`.
- R4: Whenever `early_ovf` is 1, `ovf` is also 1.
- R5: When both operands are non-zero and p+q ≤ 6, `ovf` is 0.
- R6: When either operand is zero, `prod_lo` is 0 and both `ovf` and `early_ovf` are 0.
- R7: When p+q = 7, `early_ovf` is 0 and `ovf` follows the true product: for example, 31 × 15 = 465 gives `ovf` = 1, and 16 × 15 = 240 gives `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First unsigned operand |
| op_b | input | 8 | Second unsigned operand |
| prod_lo | output | 8 | Low 8 bits of the full product |
| ovf | output | 1 | True product does not fit in 8 bits |
| early_ovf | output | 1 | Leading-one positions alone prove overflow |

## Verification
The bench sweeps every operand pair and compares the outputs against products and leading-one positions it computes itself. A design that treated the p+q = 7 band as certain overflow would flag pairs such as 16 × 15. A design that treated that band as safe would miss pairs such as 31 × 15. A leading-one detector that favoured the lowest set bit, or that reported position 0 for a zero operand, would show up as wrong warnings near the powers of two and as spurious warnings on zero operands. A product that was not truncated, or that dropped the last partial product, would show up first at the operands with bit 7 set.

// File: rtl/mulov_pkg.sv
package mulov_pkg;
  // Operand and product width shared by every module of the multiplier.
  localparam int unsigned OP_W  = 8;
  // Width of a leading-one position index.
  localparam int unsigned POS_W = $clog2(OP_W);
  // Width of the sum of two position indices.
  localparam int unsigned SUM_W = POS_W + 1;

  // Outcome of the position-based overflow estimate.
  typedef enum logic [1:0] {
    EST_SAFE   = 2'b00,
    EST_CHECK  = 2'b01,
    EST_CERTAIN = 2'b10
  } est_class_e;
endpackage

// File: rtl/mulov_lead_pos.sv
module mulov_lead_pos #(
  parameter int unsigned W   = 8,
  localparam int unsigned PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o,
  output logic          any_o
);

  // hot[i] is set when bit i is the highest set bit of the vector.
  logic [W-1:0] hot;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_hot
      if (gi == W - 1) begin : g_top
        assign hot[gi] = vec_i[gi];
      end else begin : g_low
        assign hot[gi] = vec_i[gi] & ~(|vec_i[W-1:gi+1]);
      end
    end
  endgenerate

  // Encode the one-hot vector into an index.
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (hot[i]) pos_o = pos_o | PW'(i);
    end
  end

  assign any_o = |vec_i;

  always_comb begin
    if (!$isunknown(vec_i)) begin
      // R3
      lead_pos_chk: assert (!any_o || (vec_i >> pos_o) == W'(1))
        else $error("leading-one index does not mark the highest set bit");
      // R6
      lead_zero_chk: assert (any_o || pos_o == '0)
        else $error("zero vector produced a non-zero index");
    end
  end

endmodule

// File: rtl/mulov_estimate.sv
module mulov_estimate
  import mulov_pkg::*;
#(
  parameter int unsigned W   = OP_W,
  localparam int unsigned PW = (W > 1) ? $clog2(W) : 1,
  localparam int unsigned SW = PW + 1
) (
  input  logic [PW-1:0] pos_a_i,
  input  logic [PW-1:0] pos_b_i,
  input  logic          any_a_i,
  input  logic          any_b_i,
  output est_class_e    cls_o
);

  logic [SW-1:0] pos_sum;
  assign pos_sum = SW'(pos_a_i) + SW'(pos_b_i);

  always_comb begin
    if (!(any_a_i && any_b_i)) begin
      cls_o = EST_SAFE;
    end else if (pos_sum >= SW'(W)) begin
      cls_o = EST_CERTAIN;
    end else if (pos_sum == SW'(W - 1)) begin
      cls_o = EST_CHECK;
    end else begin
      cls_o = EST_SAFE;
    end
  end

endmodule

// File: rtl/mulov_array_mult.sv
module mulov_array_mult #(
  parameter int unsigned W   = 8,
  localparam int unsigned FW = 2 * W
) (
  input  logic [W-1:0]  mcand_i,
  input  logic [W-1:0]  mplier_i,
  output logic [FW-1:0] full_o
);

  // acc[k] holds the sum of the first k partial products.
  logic [FW-1:0] acc [W+1];
  assign acc[0] = '0;

  genvar gk;
  generate
    for (gk = 0; gk < W; gk++) begin : g_row
      logic [FW-1:0] part;
      assign part       = mplier_i[gk] ? (FW'(mcand_i) << gk) : '0;
      assign acc[gk+1]  = acc[gk] + part;
    end
  endgenerate

  assign full_o = acc[W];

endmodule

// File: rtl/mulov_top.sv
module mulov_top
  import mulov_pkg::*;
(
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  output logic [OP_W-1:0] prod_lo,
  output logic            ovf,
  output logic            early_ovf
);

  localparam int unsigned FW = 2 * OP_W;

  logic [POS_W-1:0] pos_a, pos_b;
  logic             any_a, any_b;
  est_class_e       cls;
  logic [FW-1:0]    full;
  logic             hi_nz;

  mulov_lead_pos #(.W(OP_W)) lead_a_i (
    .vec_i (op_a),
    .pos_o (pos_a),
    .any_o (any_a)
  );

  mulov_lead_pos #(.W(OP_W)) lead_b_i (
    .vec_i (op_b),
    .pos_o (pos_b),
    .any_o (any_b)
  );

  mulov_estimate #(.W(OP_W)) est_i (
    .pos_a_i (pos_a),
    .pos_b_i (pos_b),
    .any_a_i (any_a),
    .any_b_i (any_b),
    .cls_o   (cls)
  );

  mulov_array_mult #(.W(OP_W)) mult_i (
    .mcand_i  (op_a),
    .mplier_i (op_b),
    .full_o   (full)
  );

  assign hi_nz     = |full[FW-1:OP_W];
  assign prod_lo   = full[OP_W-1:0];
  assign early_ovf = (cls == EST_CERTAIN);

  // Only the uncertain band consults the upper half of the product.
  always_comb begin
    unique case (cls)
      EST_CERTAIN: ovf = 1'b1;
      EST_CHECK:   ovf = hi_nz;
      default:     ovf = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_a, op_b})) begin
      // R4
      early_implies_ovf_chk: assert (!early_ovf || ovf)
        else $error("early warning without overflow");
      // R2
      ovf_matches_hi_chk: assert (ovf == hi_nz)
        else $error("overflow flag disagrees with upper product half");
      // R6
      zero_operand_chk: assert ((any_a && any_b) || (prod_lo == '0 && !ovf && !early_ovf))
        else $error("zero operand gave non-zero result or flag");
      // R5
      safe_band_chk: assert (cls != EST_SAFE || !hi_nz)
        else $error("safe estimate but product exceeds width");
    end
  end

endmodule

// File: tb/mulov_top_tb_top.sv
module mulov_top_tb_top;

  logic       clk;
  logic [7:0] op_a, op_b;
  logic [7:0] prod_lo;
  logic       ovf, early_ovf;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          done     = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  mulov_top dut_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .prod_lo   (prod_lo),
    .ovf       (ovf),
    .early_ovf (early_ovf)
  );

  function automatic int msb_pos(input int v);
    int r = -1;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp, input int a, input int b);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b);
    @(posedge clk);
    op_a = 8'(a);
    op_b = 8'(b);
    @(negedge clk);
  endtask

  initial begin
    op_a = '0;
    op_b = '0;
    @(negedge clk);
    // R6 initial state with both operands zero
    check("R6", int'(prod_lo), 0, 0, 0);
    check("R6", int'(ovf), 0, 0, 0);
    check("R6", int'(early_ovf), 0, 0, 0);

    // Directed cases from the uncertain band (R7)
    apply(31, 15);
    check("R7", int'(ovf), 1, 31, 15);
    check("R7", int'(early_ovf), 0, 31, 15);
    apply(16, 15);
    check("R7", int'(ovf), 0, 16, 15);
    check("R7", int'(early_ovf), 0, 16, 15);
    apply(255, 1);
    check("R7", int'(ovf), 0, 255, 1);
    check("R1", int'(prod_lo), 255, 255, 1);

    // Exhaustive sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        int full_p, pa, pb, sum;
        apply(a, b);
        full_p = a * b;
        pa = msb_pos(a);
        pb = msb_pos(b);
        sum = pa + pb;
        check("R1", int'(prod_lo), full_p % 256, a, b);
        check("R2", int'(ovf), (full_p > 255) ? 1 : 0, a, b);
        check("R3", int'(early_ovf), (a != 0 && b != 0 && sum >= 8) ? 1 : 0, a, b);
        if (early_ovf) check("R4", int'(ovf), 1, a, b);
        if (a != 0 && b != 0 && sum <= 6) check("R5", int'(ovf), 0, a, b);
        if (a == 0 || b == 0) check("R6", int'(prod_lo) + int'(ovf) + int'(early_ovf), 0, a, b);
        if (a != 0 && b != 0 && sum == 7) check("R7", int'(early_ovf), 0, a, b);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule